// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides, for a small 8-bit processor, when a hardware interrupt may break into the running code. Each request line has a 2-bit software priority code that software can program. The processor's current level is held in a 2-bit mask. The mask uses a non-monotonic code: `10` is level 0, the main program. `01` is level 1. `00` is level 2. `11` is level 3, where all maskable interrupts are held off.

When the processor signals the end of an instruction, the block picks the best eligible request. If it finds one, it emits a one-cycle acknowledge, a one-hot grant, the vector address and the new mask. At the same moment it saves the old mask on a four-entry nesting stack. A return pulse pops the stack and restores the saved mask. Two events cannot be masked:

- The software trap, which is serviced at any mask level.
- The reset entry, which is issued once when reset is released.

The processor's register save, the instruction decode and the memory bus are outside the block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the mask is `11`, every line's priority code is `11`, and `err` is 0. In the first clock cycle after `rst_n` rises, `ack` pulses with `vec_addr` = FFFEh and `grant` = 0.
- R2: Levels are decoded from the mask bits as follows: `10`=0, `01`=1, `00`=2, `11`=3. A request is serviced only if its programmed level is strictly above the current mask level. A request that is not serviced is not lost: it is serviced at a later boundary once the mask allows it.
- R3: Service starts only in a cycle where `insn_end` is high. `ack`, `grant`, `vec_addr` and the new `mask` appear in the next cycle. `ack` lasts one cycle, and `grant` is one-hot or zero.
- R4: Among eligible requests, the highest programmed level wins. On a tie, the lowest line index wins.
- R5: Line i has the vector address FFFAh − 2·i, the trap has FFFCh, and the reset entry has FFFEh.
- R6: When line i is serviced, the mask is loaded with line i's programmed code, and the previous mask is pushed on the nesting stack.
- R7: A trap at a boundary is serviced regardless of the mask and ahead of every request line. It sets the mask to `11`, pushes the old mask, and gives `grant` = 0.
- R8: A `reti` pulse pops the stack and restores the saved mask. In the same cycle, `reti` takes precedence over any service, and no `ack` is produced.
- R9: A `reti` with an empty stack leaves the mask unchanged and sets the sticky `err`. A fifth push onto the full four-entry stack discards the oldest entry and also sets `err`.
- R10: A pulse on `prio_we` writes `prio_wdata` as the code of line `prio_addr`. The write has no effect when `prio_addr` ≥ 14, and it does not itself change the mask or produce `ack`.
- R11: A pulse on `mask_we` loads the mask from `mask_wdata`, but only in a cycle with no `reti` and no service. Otherwise the mask changes only through R1, R6, R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 14 | Level request lines, line 0 has the highest hardware rank |
| insn_end | input | 1 | Instruction-boundary strobe |
| trap_req | input | 1 | Software trap request |
| reti | input | 1 | Return-from-interrupt pulse |
| prio_we | input | 1 | Priority code write enable |
| prio_addr | input | 4 | Line selected for the priority write |
| prio_wdata | input | 2 | Priority code to write |
| mask_we | input | 1 | Direct mask load by the processor |
| mask_wdata | input | 2 | Mask value to load |
| ack | output | 1 | One-cycle service acknowledge |
| grant | output | 14 | One-hot grant of the serviced line |
| vec_addr | output | 16 | Vector address of the serviced event |
| mask | output | 2 | Current mask bits |
| err | output | 1 | Sticky nesting stack error |

## Verification
The bound checker enforces several properties on every cycle:

- Every acknowledge except the reset entry follows a boundary strobe.
- A grant is one-hot, comes with `ack`, and matches a line that was requesting.
- Each granted line raises the decoded level strictly.
- A trap entry lands at level 3.
- The error flag never clears.
- The mask holds still whenever no event touched it.

Arbitration order, the exact vector address, and the stack contents across deep nesting and overflow depend on the programmed codes. These can only be shown by the bench's scenarios against its own model. The same holds for the precedence of `reti` over service and for ignored out-of-range priority writes.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NUM_SRC = 14,
  parameter int DEPTH = 4,
  parameter logic [15:0] VEC_TOP = 16'hFFFE,
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               insn_end,
  input  logic               trap_req,
  input  logic               reti,
  input  logic               prio_we,
  input  logic [IDXW-1:0]    prio_addr,
  input  logic [1:0]         prio_wdata,
  input  logic               mask_we,
  input  logic [1:0]         mask_wdata,
  output logic               ack,
  output logic [NUM_SRC-1:0] grant,
  output logic [15:0]        vec_addr,
  output logic [1:0]         mask,
  output logic               err
);
  localparam int DW = $clog2(DEPTH + 1);

  function automatic logic [1:0] lvl_of(input logic [1:0] code);
    case (code)
      2'b10:   return 2'd0;
      2'b01:   return 2'd1;
      2'b00:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  logic [1:0]      prio_q [NUM_SRC];
  logic [1:0]      stk_q  [DEPTH];
  logic [DW-1:0]   depth_q;
  logic            rst_pend_q;

  logic            found;
  logic [IDXW-1:0] best_idx;
  logic [1:0]      best_lvl;
  logic [1:0]      cur_lvl;

  assign cur_lvl = lvl_of(mask);

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (irq_req[i] && lvl_of(prio_q[i]) > cur_lvl &&
          (!found || lvl_of(prio_q[i]) > best_lvl)) begin
        found    = 1'b1;
        best_idx = IDXW'(i);
        best_lvl = lvl_of(prio_q[i]);
      end
    end
  end

  logic take_trap, take_irq, do_push, stk_full, stk_empty;
  assign take_trap = !rst_pend_q && !reti && insn_end && trap_req;
  assign take_irq  = !rst_pend_q && !reti && insn_end && !trap_req && found;
  assign do_push   = take_trap || take_irq;
  assign stk_full  = (depth_q == DW'(DEPTH));
  assign stk_empty = (depth_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= 2'b11;
      for (int k = 0; k < DEPTH; k++) stk_q[k] <= 2'b11;
      depth_q    <= '0;
      rst_pend_q <= 1'b1;
      mask       <= 2'b11;
      err        <= 1'b0;
      ack        <= 1'b0;
      grant      <= '0;
      vec_addr   <= '0;
    end else begin
      ack   <= 1'b0;
      grant <= '0;
      if (prio_we && int'(prio_addr) < NUM_SRC)
        prio_q[prio_addr] <= prio_wdata;
      if (rst_pend_q) begin
        rst_pend_q <= 1'b0;
        ack        <= 1'b1;
        vec_addr   <= VEC_TOP;
      end else if (reti) begin
        if (stk_empty) begin
          err <= 1'b1;
        end else begin
          mask <= stk_q[0];
          for (int k = 0; k < DEPTH - 1; k++) stk_q[k] <= stk_q[k+1];
          depth_q <= depth_q - 1'b1;
        end
      end else if (do_push) begin
        ack <= 1'b1;
        if (take_trap) begin
          mask     <= 2'b11;
          vec_addr <= VEC_TOP - 16'd2;
        end else begin
          mask            <= prio_q[best_idx];
          grant[best_idx] <= 1'b1;
          vec_addr        <= VEC_TOP - 16'd4 - 16'({best_idx, 1'b0});
        end
        stk_q[0] <= mask;
        for (int k = 1; k < DEPTH; k++) stk_q[k] <= stk_q[k-1];
        if (stk_full) err <= 1'b1;
        else depth_q <= depth_q + 1'b1;
      end else if (mask_we) begin
        mask <= mask_wdata;
      end
    end
  end
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
  parameter int NUM_SRC = 14,
  parameter logic [15:0] VEC_TOP = 16'hFFFE
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_req,
  input logic               insn_end,
  input logic               reti,
  input logic               mask_we,
  input logic               ack,
  input logic [NUM_SRC-1:0] grant,
  input logic [15:0]        vec_addr,
  input logic [1:0]         mask,
  input logic               err
);
  function automatic logic [1:0] lvl(input logic [1:0] code);
    case (code)
      2'b10:   return 2'd0;
      2'b01:   return 2'd1;
      2'b00:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // R3
  ack_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && vec_addr != VEC_TOP) |-> $past(insn_end));

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (ack && $onehot(grant)));

  // R4
  grant_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (|(grant & $past(irq_req))));

  // R2
  level_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (lvl(mask) > lvl($past(mask))));

  // R7
  trap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && vec_addr == VEC_TOP - 16'd2) |-> (mask == 2'b11 && grant == '0));

  // R8
  reti_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reti) && vec_addr != VEC_TOP) |-> !ack);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) |-> err);

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(insn_end) && !$past(reti) && !$past(mask_we)) |-> $stable(mask));
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_TOP(VEC_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_end(insn_end), .reti(reti),
  .mask_we(mask_we), .ack(ack), .grant(grant), .vec_addr(vec_addr), .mask(mask), .err(err)
);

// File: tb/nest_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nest_irq_ctrl_bench;
  localparam int NUM = 14;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM-1:0] irq_req = '0;
  logic insn_end = 0, trap_req = 0, reti = 0, prio_we = 0, mask_we = 0;
  logic [3:0] prio_addr = '0;
  logic [1:0] prio_wdata = '0, mask_wdata = '0;
  logic ack, err;
  logic [NUM-1:0] grant;
  logic [15:0] vec_addr;
  logic [1:0] mask;

  always #2.5 clk = ~clk;

  nest_irq_ctrl u_nest_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_end(insn_end), .trap_req(trap_req),
    .reti(reti), .prio_we(prio_we), .prio_addr(prio_addr), .prio_wdata(prio_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .ack(ack), .grant(grant),
    .vec_addr(vec_addr), .mask(mask), .err(err)
  );

  int n_tests = 0, n_fail = 0;
  logic [1:0] m_prio [NUM];
  logic [1:0] m_stk [DEPTH];
  int m_depth;
  logic [1:0] m_mask;
  logic m_err;

  function automatic int lv(input logic [1:0] c);
    case (c)
      2'b10: return 0;
      2'b01: return 1;
      2'b00: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int pick(input logic [NUM-1:0] rq);
    int best = -1;
    int bl = 0;
    for (int i = 0; i < NUM; i++)
      if (rq[i] && lv(m_prio[i]) > lv(m_mask) && (best < 0 || lv(m_prio[i]) > bl)) begin
        best = i;
        bl = lv(m_prio[i]);
      end
    return best;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_push(input logic [1:0] v);
    for (int k = DEPTH - 1; k > 0; k--) m_stk[k] = m_stk[k-1];
    m_stk[0] = v;
    if (m_depth == DEPTH) m_err = 1'b1;
    else m_depth++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_req = '0; insn_end = 0; trap_req = 0; reti = 0; prio_we = 0; mask_we = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NUM; i++) m_prio[i] = 2'b11;
    m_depth = 0; m_mask = 2'b11; m_err = 1'b0;
    rst_n = 1'b1;
    chk("R1 reset mask", 32'(mask), 32'h3);
    chk("R1 reset err", 32'(err), 32'h0);
    chk("R1 reset ack idle", 32'(ack), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R1 reset entry ack", 32'(ack), 32'h1);
    chk("R1 R5 reset vector", 32'(vec_addr), 32'hFFFE);
    chk("R1 reset entry grant", 32'(grant), 32'h0);
  endtask

  task automatic step(input logic [NUM-1:0] rq, input logic ie, input logic tr, input logic rt,
                      input logic mwe, input logic [1:0] mwd, input string tag);
    logic e_ack;
    logic [NUM-1:0] e_gnt;
    logic [15:0] e_vec;
    int w;
    irq_req = rq; insn_end = ie; trap_req = tr; reti = rt; mask_we = mwe; mask_wdata = mwd;
    e_ack = 0; e_gnt = '0; e_vec = '0;
    w = pick(rq);
    if (rt) begin
      if (m_depth == 0) m_err = 1'b1;
      else begin
        m_mask = m_stk[0];
        for (int k = 0; k < DEPTH - 1; k++) m_stk[k] = m_stk[k+1];
        m_depth--;
      end
    end else if (ie && (tr || w >= 0)) begin
      m_push(m_mask);
      e_ack = 1'b1;
      if (tr) begin
        m_mask = 2'b11; e_vec = 16'hFFFC;
      end else begin
        e_gnt[w] = 1'b1; m_mask = m_prio[w]; e_vec = 16'hFFFA - 16'(2 * w);
      end
    end else if (mwe) m_mask = mwd;
    @(posedge clk); @(negedge clk);
    chk({tag, " ack"}, 32'(ack), 32'(e_ack));
    chk({tag, " grant"}, 32'(grant), 32'(e_gnt));
    chk({tag, " mask"}, 32'(mask), 32'(m_mask));
    chk({tag, " err"}, 32'(err), 32'(m_err));
    if (e_ack) chk({tag, " vector"}, 32'(vec_addr), 32'(e_vec));
    irq_req = '0; insn_end = 0; trap_req = 0; reti = 0; mask_we = 0;
  endtask

  task automatic wprio(input logic [3:0] a, input logic [1:0] d);
    prio_we = 1'b1; prio_addr = a; prio_wdata = d;
    @(posedge clk); @(negedge clk);
    prio_we = 1'b0;
    if (int'(a) < NUM) m_prio[a] = d;
    chk("R10 write no ack", 32'(ack), 32'h0);
    chk("R10 write keeps mask", 32'(mask), 32'(m_mask));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    step(14'h0008, 1, 0, 0, 0, 2'b00, "R2 equal level3 held off");
    step('0, 0, 0, 0, 1, 2'b10, "R11 mask load level0");
    step(14'h0008, 0, 0, 0, 0, 2'b00, "R3 no boundary no service");
    step(14'h0008, 1, 0, 0, 0, 2'b00, "R5 R6 line3 service");
    step('0, 0, 0, 1, 0, 2'b00, "R8 return restores");
    wprio(4'd2, 2'b01);
    wprio(4'd5, 2'b00);
    wprio(4'd7, 2'b00);
    step(14'h00A4, 1, 0, 0, 0, 2'b00, "R4 level then index arbitration");
    step(14'h0084, 1, 0, 0, 0, 2'b00, "R2 lower and equal stay pending");
    step(14'h0084, 1, 1, 0, 0, 2'b00, "R7 trap beats mask and lines");
    step('0, 0, 0, 1, 1, 2'b01, "R8 R11 return beats mask load");
    step(14'h0084, 1, 0, 1, 0, 2'b00, "R8 return beats service");
    step(14'h0084, 1, 0, 0, 0, 2'b00, "R2 pending request served later");
    step('0, 0, 0, 1, 0, 2'b00, "R8 return to main");
    step('0, 0, 0, 1, 0, 2'b00, "R9 empty pop");
    step('0, 0, 0, 0, 1, 2'b01, "R9 err sticky");
    do_reset();
    wprio(4'd14, 2'b10);
    wprio(4'd15, 2'b10);
    step('0, 0, 0, 0, 1, 2'b10, "R11 mask load");
    step(14'h0001, 1, 0, 0, 0, 2'b00, "R10 out-of-range write ignored");
    for (int i = 0; i < 5; i++) step('0, 1, 1, 0, 0, 2'b00, "R9 R7 trap nesting overflow");
    for (int i = 0; i < 5; i++) step('0, 0, 0, 1, 0, 2'b00, "R9 R8 unwind after overflow");
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] u;
      u = $urandom;
      if (n % 40 == 0) wprio(4'($urandom % 16), 2'($urandom));
      step(NUM'($urandom & $urandom), u[1:0] != 2'b00, u[7:2] == 6'd0, u[11:8] < 4'd3,
           u[15:12] == 4'd0, u[17:16], "R4 R6 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule